// File: doc/BRIEF.md
# Stall and Delay-Slot Squash Control for a Forwarding-Free Pipeline

This unit supplies the hazard control for a five-stage, in-order pipeline that has no bypass paths. Every cycle it compares the two source register fields of the instruction in decode with the destination fields of the instructions in execute, memory and write-back. If any of them is about to write one of those registers, decode is frozen. In that case the program counter and the fetch/decode register hold their values, and the decode/execute register receives a bubble with all control cleared. The write-back stage also counts as a hazard source, because the register file makes a written value readable only in the following cycle.

Branches are decided late, in execute. Each branch therefore has two delay slots. The first slot is an ordinary instruction placed there by the compiler. The unit marks the second slot, and that instruction arrives in decode flagged as a NOP. The mark travels with the fetch/decode register: it waits while decode is stalled and takes effect when the instruction moves on. A squashed decode slot has no operands, so it never causes a stall and never arms a new squash.

If a taken branch reaches execute while decode is stalled, the program counter is released so that it can load the branch target. The second-slot instruction that was being fetched is then thrown away, and its pending squash mark is cancelled.

Top module: `hzd_ctrl`

## Requirements
- R1: A decode source (rs or rt) equal to the execute-stage destination, with that stage's write enable high, drives pc_hold, ifid_hold and idex_bubble high in the same cycle (combinational).
- R2: A match against the memory-stage or the write-back-stage destination, with its write enable high, stalls in exactly the same way as R1. A write-back match stalls because written data is readable only one cycle later.
- R3: A stage counts as a hazard only if its write enable is 1 and its destination is not register 0.
- R4: With no qualifying match and no squash pending, all of pc_hold, ifid_hold and idex_bubble are 0.
- R5: Both the rs field and the rt field are compared, each on its own.
- R6: A branch flagged in decode that advances (ifid_hold=0) makes id_squash equal 0 on the next cycle (first delay slot) and 1 on the cycle after that (second delay slot), provided both cycles advance.
- R7: While decode is stalled, a pending squash mark is held. It reaches id_squash only after the stalled instruction advances.
- R8: While id_squash is 1, no source match stalls, and a branch flag in decode is ignored.
- R9: When ex_br_taken is 1 during a data stall, pc_hold is 0 while ifid_hold and idex_bubble stay 1. The pending squash mark is then cancelled, so the next instruction to enter decode has id_squash=0.
- R10: Synchronous active-high reset clears all squash state, so id_squash is 0 after reset and no mark armed before reset survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs | input | AW | First source register of the decode instruction |
| id_rt | input | AW | Second source register of the decode instruction |
| id_is_branch | input | 1 | Decode instruction is a branch |
| ex_rd | input | AW | Execute-stage destination register |
| ex_we | input | 1 | Execute-stage register write enable |
| mem_rd | input | AW | Memory-stage destination register |
| mem_we | input | 1 | Memory-stage register write enable |
| wb_rd | input | AW | Write-back-stage destination register |
| wb_we | input | 1 | Write-back-stage register write enable |
| ex_br_taken | input | 1 | Branch in execute resolved taken |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a cleared bubble into decode/execute |
| id_squash | output | 1 | Decode slot holds a squashed (NOP) instruction |

## Verification
The bench sweeps every stage, write enable and a dense set of register numbers, including register 0, against both source fields. A design that dropped the write-back compare, compared only rs, or let register 0 or a non-writing stage stall would fail this sweep. A set of clocked sequences then walks a branch through its two delay slots. The sequences cover a clean advance, a stalled first slot, a taken branch resolving during that stall, and a reset in the middle of a sequence. A design that squashed the wrong slot, lost or advanced the mark during a stall, kept a stale mark after a redirect, or let a squashed slot stall would fail these sequences.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int REG_AW      = 5;
    localparam int N_WR_STAGES = 3;

    typedef enum logic [1:0] {
        STG_EX  = 2'd0,
        STG_MEM = 2'd1,
        STG_WB  = 2'd2
    } wr_stage_e;

    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic idex_bubble;
    } stall_ctl_t;

    function automatic stall_ctl_t make_stall(input logic data_stall, input logic redirect);
        stall_ctl_t c;
        c.pc_hold     = data_stall & ~redirect;
        c.ifid_hold   = data_stall;
        c.idex_bubble = data_stall;
        return c;
    endfunction

endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] dst,
    input  logic          wr,
    input  logic [AW-1:0] src_a,
    input  logic [AW-1:0] src_b,
    output logic          hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic live;
    logic eq_a;
    logic eq_b;

    always_comb begin
        live = wr && (dst != ZERO_REG);
        eq_a = (dst == src_a);
        eq_b = (dst == src_b);
        hit  = live && (eq_a || eq_b);
    end
endmodule

// File: rtl/hzd_slot_tracker.sv
module hzd_slot_tracker (
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  logic branch_in_id,
    input  logic redirect,
    output logic squash_id
);
    logic pend_q;
    logic sq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            sq_q   <= 1'b0;
        end else if (advance) begin
            sq_q   <= pend_q;
            pend_q <= branch_in_id && !sq_q;
        end else if (redirect) begin
            pend_q <= 1'b0;
        end
    end

    assign squash_id = sq_q;

    // R7: a held decode slot keeps its squash flag
    p_hold_keeps_flag_r7: assert property (@(posedge clk) disable iff (rst)
        !advance |=> (sq_q == $past(sq_q)));

    // R9: a redirect during a stall leaves no pending mark
    p_redirect_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (!advance && redirect) |=> !pend_q);
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl #(
    parameter int AW = hzd_pkg::REG_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic          id_is_branch,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    input  logic          ex_br_taken,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble,
    output logic          id_squash
);
    import hzd_pkg::*;

    localparam int NS = N_WR_STAGES;

    logic [AW-1:0] st_dst [NS];
    logic [NS-1:0] st_wr;
    logic [NS-1:0] st_hit;
    logic          data_stall;
    logic          squash_q;
    stall_ctl_t    ctl;

    always_comb begin
        st_dst[STG_EX]  = ex_rd;
        st_dst[STG_MEM] = mem_rd;
        st_dst[STG_WB]  = wb_rd;
        st_wr[STG_EX]   = ex_we;
        st_wr[STG_MEM]  = mem_we;
        st_wr[STG_WB]   = wb_we;
    end

    for (genvar g = 0; g < NS; g++) begin : g_cmp
        hzd_src_cmp #(.AW(AW)) u_cmp (
            .dst   (st_dst[g]),
            .wr    (st_wr[g]),
            .src_a (id_rs),
            .src_b (id_rt),
            .hit   (st_hit[g])
        );
    end

    // a squashed slot is a NOP and has no operands
    assign data_stall = (|st_hit) && !squash_q;

    hzd_slot_tracker u_trk (
        .clk          (clk),
        .rst          (rst),
        .advance      (!data_stall),
        .branch_in_id (id_is_branch),
        .redirect     (ex_br_taken),
        .squash_id    (squash_q)
    );

    always_comb begin
        ctl         = make_stall(data_stall, ex_br_taken);
        pc_hold     = ctl.pc_hold;
        ifid_hold   = ctl.ifid_hold;
        idex_bubble = ctl.idex_bubble;
        id_squash   = squash_q;
    end

    // R1: holding decode always comes with a bubble downstream
    p_hold_has_bubble_r1: assert property (@(posedge clk) disable iff (rst)
        ifid_hold |-> idex_bubble);

    // R3: a register-0 writer alone never stalls
    p_zero_dst_r3: assert property (@(posedge clk) disable iff (rst)
        (ex_we && ex_rd == '0 && !mem_we && !wb_we) |-> !ifid_hold);

    // R8: a squashed decode slot never stalls
    p_squash_no_stall_r8: assert property (@(posedge clk) disable iff (rst)
        id_squash |-> !ifid_hold);

    // R6: the first delay slot is never squashed
    p_slot1_clean_r6: assert property (@(posedge clk) disable iff (rst)
        (id_is_branch && !ifid_hold && !id_squash) |=> !id_squash);

    // R9: a taken branch frees the PC during a stall
    p_redirect_pc_r9: assert property (@(posedge clk) disable iff (rst)
        (ifid_hold && ex_br_taken) |-> !pc_hold);
endmodule

// File: tb/test_hzd_ctrl.sv
module test_hzd_ctrl;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] id_rs = '0, id_rt = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic          id_is_branch = 1'b0, ex_we = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
    logic          ex_br_taken = 1'b0;
    logic          pc_hold, ifid_hold, idex_bubble, id_squash;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    hzd_ctrl #(.AW(AW)) i_hzd_ctrl (
        .clk(clk), .rst(rst), .id_rs(id_rs), .id_rt(id_rt), .id_is_branch(id_is_branch),
        .ex_rd(ex_rd), .ex_we(ex_we), .mem_rd(mem_rd), .mem_we(mem_we),
        .wb_rd(wb_rd), .wb_we(wb_we), .ex_br_taken(ex_br_taken),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .id_squash(id_squash)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {pc,ifid,bub,sq} got %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {pc_hold, ifid_hold, idex_bubble, id_squash};
    endfunction

    task automatic quiet();
        id_rs = 5'd1; id_rt = 5'd2; ex_we = 0; mem_we = 0; wb_we = 0;
        ex_rd = 5'd9; mem_rd = 5'd9; wb_rd = 5'd9; id_is_branch = 0; ex_br_taken = 0;
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        quiet();
        step(); step();
        rst = 0;
        #1;
        check("R10 reset state", outs(), 4'b0000);
        check("R4 idle", outs(), 4'b0000);

        // R1 R2 R3 R5 sweep: one writing stage at a time, others idle
        for (int stg = 0; stg < 3; stg++)
            for (int we = 0; we < 2; we++)
                for (int rd = 0; rd < 8; rd++)
                    for (int a = 0; a < 8; a++)
                        for (int b = 0; b < 8; b++) begin
                            logic e;
                            quiet();
                            id_rs = 5'(a); id_rt = 5'(b * 3);
                            if (stg == 0) begin ex_rd = 5'(rd); ex_we = 1'(we); end
                            if (stg == 1) begin mem_rd = 5'(rd); mem_we = 1'(we); end
                            if (stg == 2) begin wb_rd = 5'(rd); wb_we = 1'(we); end
                            #1;
                            e = (we == 1) && (rd != 0) && (rd == a || rd == b * 3);
                            if (stg == 0) check("R1 R3 R5 ex sweep", outs(), {e, e, e, 1'b0});
                            else          check("R2 R3 R5 mem/wb sweep", outs(), {e, e, e, 1'b0});
                        end
        // R2 three stages together
        for (int k = 0; k < 32; k++) begin
            logic e;
            quiet();
            id_rs = 5'(k); id_rt = 5'(31 - k);
            ex_rd = 5'(k ^ 5); ex_we = 1'(k % 2);
            mem_rd = 5'(k + 1); mem_we = 1;
            wb_rd = 5'(30 - k); wb_we = 1'(k % 3 == 0);
            #1;
            e = (ex_we && ex_rd != 0 && (ex_rd == id_rs || ex_rd == id_rt)) ||
                (mem_rd != 0 && (mem_rd == id_rs || mem_rd == id_rt)) ||
                (wb_we && wb_rd != 0 && (wb_rd == id_rs || wb_rd == id_rt));
            check("R2 combined stages", outs(), {e, e, e, 1'b0});
        end

        // R6 R8 clean branch
        quiet(); id_is_branch = 1; step();
        id_is_branch = 0; #1;
        check("R6 first slot not squashed", outs(), 4'b0000);
        step();
        check("R6 second slot squashed", outs(), 4'b0001);
        id_rs = 5'd4; ex_rd = 5'd4; ex_we = 1; id_is_branch = 1; #1;
        check("R8 squashed slot ignores match", outs(), 4'b0001);
        step();
        id_is_branch = 0; ex_we = 0; #1;
        check("R8 squashed branch flag not armed / R6 one cycle", outs(), 4'b0000);
        step();
        check("R8 no late squash", outs(), 4'b0000);

        // R7 first slot stalls
        quiet(); id_is_branch = 1; step();
        id_is_branch = 0; id_rt = 5'd7; mem_rd = 5'd7; mem_we = 1; #1;
        check("R7 stall on slot1", outs(), 4'b1110);
        step();
        check("R7 still stalled, mark held", outs(), 4'b1110);
        mem_we = 0; wb_rd = 5'd7; wb_we = 1; #1;
        check("R2 wb stall on slot1", outs(), 4'b1110);
        step();
        wb_we = 0; #1;
        check("R7 slot1 released", outs(), 4'b0000);
        step();
        check("R7 squash after release", outs(), 4'b0001);
        step();

        // R9 taken branch during stall
        quiet(); id_is_branch = 1; step();
        id_is_branch = 0; id_rs = 5'd3; ex_rd = 5'd3; ex_we = 1; ex_br_taken = 1; #1;
        check("R9 pc released on redirect", outs(), 4'b0110);
        step();
        ex_br_taken = 0; ex_we = 0; #1;
        check("R9 slot1 advances", outs(), 4'b0000);
        step();
        check("R9 mark cancelled", outs(), 4'b0000);

        // R10 reset mid-sequence
        quiet(); id_is_branch = 1; step();
        id_is_branch = 0; rst = 1; step();
        rst = 0; step();
        check("R10 mark cleared by reset", outs(), 4'b0000);
        step();
        check("R10 stays clear", outs(), 4'b0000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule